// File: doc/BRIEF.md
# 100BASE-X Receive Code-Group Checker

This block sits behind the descrambler and code-group aligner of a 100BASE-X receive path. On every cycle that the alignment stage marks valid, it accepts one 5-bit code-group. It turns data groups into nibbles and tracks frame boundaries from the start pair and the end pair. It raises a receive-error output when something other than data shows up inside a frame. Every accepted group is also classified, and the block raises a separate flag for each code-group that has no meaning at all.

A 16-bit error counter records frames that carried at least one meaningless group. The counter adds one per frame, no matter how many bad groups that frame holds. It wraps past its maximum and is cleared only by reset. Its value is always visible on an output bus, so reading it has no side effect. A lock supervisor watches for IDLE groups. If a full window of accepted groups passes with no IDLE (8000 groups by default, which is 4000 bytes), it drops lock. It then aborts any frame in progress and ignores everything until the next IDLE restores lock.

Top module: `sym_rx_checker`

## Requirements
- R1: A data code-group inside a frame drives `rx_dv`=1, `rx_er`=0, and `rx_data` equal to its nibble. The mapping from nibble 0 to nibble F is: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R2: The six control groups are IDLE 11111, J 11000, K 10001, T 01101, R 00111 and H 00100. Any group that is neither data nor one of these six is invalid. Examples are 00010, 00011, 00101, 01000, 01100, 10000 and also 00000, 00001, 00110 and 11001. For every accepted group, `sym_invalid` shows whether that group was invalid, whatever the frame or lock state.
- R3: A frame opens with J immediately followed by K. Both J and K output `rx_dv`=0, and `rx_dv` rises with the output of the group after K. If J is followed by anything other than K or J, no frame opens.
- R4: In a frame, T outputs `rx_dv`=1 with `rx_er`=0. An R right after T closes the frame with `rx_dv`=0. Any other group after T outputs `rx_dv`=1 and `rx_er`=1, and then closes the frame.
- R5: The first IDLE in a frame outputs `rx_dv`=1 and `rx_er`=1. A second IDLE in a row closes the frame with `rx_dv`=0. Any other group after a single IDLE continues the frame as usual.
- R6: An invalid group, H, or a stray J, K or R inside a frame outputs `rx_dv`=1 and `rx_er`=1. `rx_data` is 0 for every output that is not a data group.
- R7: The error counter adds one on the first invalid group of a frame and ignores further invalid groups in the same frame. Invalid groups outside a frame are not counted.
- R8: The counter wraps from all-ones to 0. Only reset clears it.
- R9: `locked` is 0 after reset and becomes 1 on any accepted IDLE. It drops on the WIN_SYMS-th consecutive accepted non-IDLE group. That group, and every group accepted while unlocked, outputs `rx_dv`=0 and `rx_er`=0, closes any open frame, and is never counted.
- R10: After reset all outputs are 0. Outputs change only on cycles with `cg_valid`=1, and they hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cg_valid | input | 1 | A code-group is presented this cycle |
| cg_code | input | 5 | Aligned, descrambled code-group |
| rx_dv | output | 1 | Frame data valid for the last accepted group |
| rx_er | output | 1 | Receive error for the last accepted group |
| rx_data | output | 4 | Decoded nibble of the last accepted group |
| sym_invalid | output | 1 | Last accepted group was an invalid code |
| locked | output | 1 | Lock supervisor state |
| err_count | output | CNT_W | Errored-frame counter, 16 bits by default |

## Verification
The lock timeout and the error counter can fall on the same accepted group: an invalid code inside an open frame can be exactly the group that exhausts the IDLE window. The bench places the IDLE so that J, K and then an invalid group land on counts WIN_SYMS-2, WIN_SYMS-1 and WIN_SYMS. It then expects the abort to win: `sym_invalid` high, `rx_dv` and `rx_er` low, `locked` low, and the counter unchanged. A behavioural model compared on every clock judges all other cycles, including the per-frame count limit and wrap-around.

// File: rtl/sym_rx_pkg.sv
package sym_rx_pkg;

  // Class of one received code-group
  typedef enum logic [2:0] {
    CG_DATA,
    CG_IDLE,
    CG_J,
    CG_K,
    CG_T,
    CG_R,
    CG_H,
    CG_BAD
  } cg_class_e;

  // Frame tracker states
  typedef enum logic [2:0] {
    FR_OUT,
    FR_GOT_J,
    FR_BODY,
    FR_ONE_IDLE,
    FR_GOT_T
  } fr_state_e;

  typedef struct packed {
    cg_class_e  cls;
    logic [3:0] nib;
  } cg_dec_t;

endpackage

// File: rtl/sym_rx_decode.sv
module sym_rx_decode
  import sym_rx_pkg::*;
(
  input  logic [4:0] cg,
  output cg_dec_t    dec
);

  always_comb begin
    dec.cls = CG_DATA;
    dec.nib = 4'h0;
    case (cg)
      5'b11110: dec.nib = 4'h0;
      5'b01001: dec.nib = 4'h1;
      5'b10100: dec.nib = 4'h2;
      5'b10101: dec.nib = 4'h3;
      5'b01010: dec.nib = 4'h4;
      5'b01011: dec.nib = 4'h5;
      5'b01110: dec.nib = 4'h6;
      5'b01111: dec.nib = 4'h7;
      5'b10010: dec.nib = 4'h8;
      5'b10011: dec.nib = 4'h9;
      5'b10110: dec.nib = 4'hA;
      5'b10111: dec.nib = 4'hB;
      5'b11010: dec.nib = 4'hC;
      5'b11011: dec.nib = 4'hD;
      5'b11100: dec.nib = 4'hE;
      5'b11101: dec.nib = 4'hF;
      5'b11111: dec.cls = CG_IDLE;
      5'b11000: dec.cls = CG_J;
      5'b10001: dec.cls = CG_K;
      5'b01101: dec.cls = CG_T;
      5'b00111: dec.cls = CG_R;
      5'b00100: dec.cls = CG_H;
      default:  dec.cls = CG_BAD;
    endcase
  end

endmodule

// File: rtl/sym_rx_lock.sv
module sym_rx_lock #(
  parameter int WIN_SYMS = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cg_valid,
  input  logic is_idle,
  output logic locked,
  output logic timeout
);

  localparam int CW = (WIN_SYMS > 2) ? $clog2(WIN_SYMS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_SYMS - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          lock_q, lock_n;

  always_comb begin
    cnt_n   = cnt_q;
    lock_n  = lock_q;
    timeout = 1'b0;
    if (cg_valid) begin
      if (is_idle) begin
        cnt_n  = '0;
        lock_n = 1'b1;
      end else if (lock_q) begin
        if (cnt_q == LAST) begin
          cnt_n   = '0;
          lock_n  = 1'b0;
          timeout = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (cg_valid) begin
      cnt_q  <= cnt_n;
      lock_q <= lock_n;
    end
  end

  assign locked = lock_q;

endmodule

// File: rtl/sym_rx_framer.sv
module sym_rx_framer
  import sym_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cg_valid,
  input  logic       active,
  input  cg_dec_t    dec,
  output logic       rx_dv,
  output logic       rx_er,
  output logic [3:0] rx_data,
  output logic       count_pulse
);

  fr_state_e  st_q, st_n;
  logic       dv_q, dv_n, er_q, er_n, seen_q, seen_n;
  logic [3:0] dat_q, dat_n;
  logic       bad_hit;

  always_comb begin
    st_n    = st_q;
    dv_n    = 1'b0;
    er_n    = 1'b0;
    dat_n   = 4'h0;
    seen_n  = seen_q;
    bad_hit = 1'b0;
    if (!active) begin
      st_n   = FR_OUT;
      seen_n = 1'b0;
    end else begin
      case (st_q)
        FR_OUT: begin
          if (dec.cls == CG_J) st_n = FR_GOT_J;
        end
        FR_GOT_J: begin
          if (dec.cls == CG_K) begin
            st_n   = FR_BODY;
            seen_n = 1'b0;
          end else if (dec.cls != CG_J) begin
            st_n = FR_OUT;
          end
        end
        FR_BODY, FR_ONE_IDLE: begin
          dv_n = 1'b1;
          st_n = FR_BODY;
          case (dec.cls)
            CG_DATA: dat_n = dec.nib;
            CG_T:    st_n  = FR_GOT_T;
            CG_IDLE: begin
              if (st_q == FR_ONE_IDLE) begin
                dv_n = 1'b0;
                st_n = FR_OUT;
              end else begin
                er_n = 1'b1;
                st_n = FR_ONE_IDLE;
              end
            end
            default: begin
              er_n    = 1'b1;
              bad_hit = (dec.cls == CG_BAD);
            end
          endcase
        end
        FR_GOT_T: begin
          st_n = FR_OUT;
          if (dec.cls != CG_R) begin
            dv_n    = 1'b1;
            er_n    = 1'b1;
            bad_hit = (dec.cls == CG_BAD);
          end
        end
        default: st_n = FR_OUT;
      endcase
    end
    if (bad_hit && !seen_q) seen_n = 1'b1;
  end

  assign count_pulse = cg_valid && bad_hit && !seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_OUT;
      dv_q   <= 1'b0;
      er_q   <= 1'b0;
      dat_q  <= 4'h0;
      seen_q <= 1'b0;
    end else if (cg_valid) begin
      st_q   <= st_n;
      dv_q   <= dv_n;
      er_q   <= er_n;
      dat_q  <= dat_n;
      seen_q <= seen_n;
    end
  end

  assign rx_dv   = dv_q;
  assign rx_er   = er_q;
  assign rx_data = dat_q;

endmodule

// File: rtl/sym_rx_errcnt.sv
module sym_rx_errcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_n;
  end

  assign count = cnt_q;

endmodule

// File: rtl/sym_rx_checker.sv
module sym_rx_checker
  import sym_rx_pkg::*;
#(
  parameter int WIN_SYMS = 8000,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cg_valid,
  input  logic [4:0]       cg_code,
  output logic             rx_dv,
  output logic             rx_er,
  output logic [3:0]       rx_data,
  output logic             sym_invalid,
  output logic             locked,
  output logic [CNT_W-1:0] err_count
);

  logic [1:0] rst_sync;
  logic       rst_int_n;
  cg_dec_t    dec;
  logic       timeout, lock_q, count_pulse, inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  sym_rx_decode u_dec (
    .cg  (cg_code),
    .dec (dec)
  );

  sym_rx_lock #(.WIN_SYMS(WIN_SYMS)) u_lock (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cg_valid (cg_valid),
    .is_idle  (dec.cls == CG_IDLE),
    .locked   (lock_q),
    .timeout  (timeout)
  );

  sym_rx_framer u_frm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cg_valid    (cg_valid),
    .active      (lock_q && !timeout),
    .dec         (dec),
    .rx_dv       (rx_dv),
    .rx_er       (rx_er),
    .rx_data     (rx_data),
    .count_pulse (count_pulse)
  );

  sym_rx_errcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .inc   (count_pulse),
    .count (err_count)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    inv_q <= 1'b0;
    else if (cg_valid) inv_q <= (dec.cls == CG_BAD);
  end

  assign sym_invalid = inv_q;
  assign locked      = lock_q;

endmodule

// File: rtl/sym_rx_checker_sva.sv
module sym_rx_checker_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cg_valid,
  input logic             rx_dv,
  input logic             rx_er,
  input logic [3:0]       rx_data,
  input logic             sym_invalid,
  input logic             locked,
  input logic [CNT_W-1:0] err_count
);

  AST_DATA_ZERO_OFF_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dv |-> rx_data == 4'h0);  // R6

  AST_INVALID_IN_FRAME_ER: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_invalid && rx_dv) |-> rx_er);  // R6

  AST_UNLOCKED_NO_DV: assert property (@(posedge clk) disable iff (!rst_n)
    (cg_valid && !locked) |=> (!rx_dv && !rx_er));  // R9

  AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_count) |-> err_count == CNT_W'($past(err_count) + 1'b1));  // R8

  AST_CNT_NEEDS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_count) |-> (sym_invalid && rx_er));  // R7

  AST_HOLD_NO_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    !cg_valid |=> ($stable(rx_dv) && $stable(rx_er) && $stable(rx_data)
                   && $stable(sym_invalid) && $stable(locked)));  // R10

endmodule

bind sym_rx_checker sym_rx_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .cg_valid    (cg_valid),
  .rx_dv       (rx_dv),
  .rx_er       (rx_er),
  .rx_data     (rx_data),
  .sym_invalid (sym_invalid),
  .locked      (locked),
  .err_count   (err_count)
);

// File: tb/sym_rx_checker_tb.sv
`timescale 1ns/1ps
module sym_rx_checker_tb;

  localparam int WIN   = 40;
  localparam int CNT_W = 8;
  localparam logic [4:0] C_I = 5'b11111, C_J = 5'b11000, C_K = 5'b10001;
  localparam logic [4:0] C_T = 5'b01101, C_R = 5'b00111, C_H = 5'b00100;
  localparam logic [4:0] C_V = 5'b00010;
  localparam logic [4:0] DC [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                                     5'b01010, 5'b01011, 5'b01110, 5'b01111,
                                     5'b10010, 5'b10011, 5'b10110, 5'b10111,
                                     5'b11010, 5'b11011, 5'b11100, 5'b11101};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cg_valid = 1'b0;
  logic [4:0] cg_code = 5'b0;
  logic rx_dv, rx_er, sym_invalid, locked;
  logic [3:0] rx_data;
  logic [CNT_W-1:0] err_count;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sym_rx_checker #(.WIN_SYMS(WIN), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cg_valid(cg_valid), .cg_code(cg_code),
    .rx_dv(rx_dv), .rx_er(rx_er), .rx_data(rx_data),
    .sym_invalid(sym_invalid), .locked(locked), .err_count(err_count)
  );

  // ---------------- behavioural reference ----------------
  // kind: 0 data, 1 idle, 2 J, 3 K, 4 T, 5 R, 6 H, 7 invalid
  // phase: 0 outside, 1 after J, 2 in frame, 3 one idle seen, 4 after T
  int m_phase = 0, m_win = 0, m_cnt = 0;
  bit m_dv = 0, m_er = 0, m_inv = 0, m_lock = 0, m_seen = 0;
  int m_data = 0;

  function automatic int kind_of(input logic [4:0] c, output int nib);
    nib = 0;
    for (int i = 0; i < 16; i++) if (DC[i] == c) begin nib = i; return 0; end
    if (c == C_I) return 1;
    if (c == C_J) return 2;
    if (c == C_K) return 3;
    if (c == C_T) return 4;
    if (c == C_R) return 5;
    if (c == C_H) return 6;
    return 7;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_win = 0; m_cnt = 0; m_dv = 0; m_er = 0;
      m_inv = 0; m_lock = 0; m_seen = 0; m_data = 0;
    end else if (cg_valid) begin
      int k, nib;
      bit expire, was_lock, err_bad;
      k = kind_of(cg_code, nib);
      m_inv = (k == 7);
      expire = 0;
      was_lock = m_lock;
      if (k == 1) begin m_win = 0; m_lock = 1; end
      else if (m_lock) begin
        m_win++;
        if (m_win == WIN) begin expire = 1; m_win = 0; m_lock = 0; end
      end
      m_dv = 0; m_er = 0; m_data = 0; err_bad = 0;
      if (!was_lock || expire) m_phase = 0;
      else if (m_phase == 0) begin
        if (k == 2) m_phase = 1;
      end else if (m_phase == 1) begin
        if (k == 3) begin m_phase = 2; m_seen = 0; end
        else if (k != 2) m_phase = 0;
      end else if (m_phase == 4) begin
        m_phase = 0;
        if (k != 5) begin m_dv = 1; m_er = 1; err_bad = (k == 7); end
      end else begin
        m_dv = 1;
        if (k == 0) begin m_data = nib; m_phase = 2; end
        else if (k == 4) m_phase = 4;
        else if (k == 1) begin
          if (m_phase == 3) begin m_dv = 0; m_phase = 0; end
          else begin m_er = 1; m_phase = 3; end
        end else begin m_er = 1; m_phase = 2; err_bad = (k == 7); end
      end
      if (err_bad && !m_seen) begin
        m_seen = 1;
        m_cnt = (m_cnt + 1) % (1 << CNT_W);
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (rx_data !== 4'(m_data)) begin errors++;
      $display("FAIL R1 model rx_data actual %0d expected %0d", rx_data, m_data); end
    if (sym_invalid !== m_inv) begin errors++;
      $display("FAIL R2 model sym_invalid actual %0b expected %0b", sym_invalid, m_inv); end
    if (rx_dv !== m_dv) begin errors++;
      $display("FAIL R3 model rx_dv actual %0b expected %0b", rx_dv, m_dv); end
    if (rx_er !== m_er) begin errors++;
      $display("FAIL R6 model rx_er actual %0b expected %0b", rx_er, m_er); end
    if (locked !== m_lock) begin errors++;
      $display("FAIL R9 model locked actual %0b expected %0b", locked, m_lock); end
    if (int'(err_count) != m_cnt) begin errors++;
      $display("FAIL R7 model err_count actual %0d expected %0d", err_count, m_cnt); end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [4:0] c);
    cg_valid = 1'b1;
    cg_code  = c;
    @(negedge clk);
    cg_valid = 1'b0;
  endtask

  task automatic gap(input int n);
    cg_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL R10 watchdog actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c0, n;
    repeat (3) @(negedge clk);
    chk("R10 reset rx_dv", rx_dv, 0);
    chk("R10 reset count", err_count, 0);
    chk("R9 reset locked", locked, 0);
    rst_n = 1'b1;
    gap(5);

    // unlocked: frame ignored, invalid still flagged
    send(C_J); send(C_K); send(DC[3]);
    chk("R9 unlocked no dv", rx_dv, 0);
    send(C_V);
    chk("R2 invalid flag while unlocked", sym_invalid, 1);
    chk("R7 no count while unlocked", err_count, 0);
    send(5'b11001);
    chk("R2 11001 invalid", sym_invalid, 1);
    send(C_I);
    chk("R9 idle locks", locked, 1);

    // clean frame with all nibbles
    send(C_J); chk("R3 J no dv", rx_dv, 0);
    send(C_K); chk("R3 K no dv", rx_dv, 0);
    for (int i = 0; i < 16; i++) begin
      send(DC[i]);
      chk("R1 data nibble", rx_data, i);
      chk("R1 data dv", rx_dv, 1);
    end
    gap(3);
    chk("R10 hold during gap", rx_data, 15);
    send(C_T); chk("R4 T keeps dv", rx_dv, 1); chk("R4 T no er", rx_er, 0);
    send(C_R); chk("R4 R drops dv", rx_dv, 0);
    send(C_I);

    // J without K
    send(C_J); send(DC[5]); chk("R3 J then data no dv", rx_dv, 0);
    send(DC[5]); chk("R3 still closed", rx_dv, 0);
    send(C_I);

    // H and repeated invalid, counted once
    c0 = err_count;
    send(C_J); send(C_K); send(C_H);
    chk("R6 H raises er", rx_er, 1); chk("R6 H data zero", rx_data, 0);
    send(C_V); chk("R6 invalid er", rx_er, 1);
    send(5'b01100); send(DC[1]);
    chk("R7 once per frame", err_count, c0 + 1);
    send(C_T); send(C_R); send(C_I);
    send(C_V); chk("R7 no count outside frame", err_count, c0 + 1);

    // premature end
    send(C_J); send(C_K); send(DC[2]);
    send(C_I); chk("R5 first idle er", rx_er, 1); chk("R5 first idle dv", rx_dv, 1);
    send(DC[4]); chk("R5 continues", rx_dv, 1); chk("R5 data after idle", rx_data, 4);
    send(C_I); send(C_I); chk("R5 second idle ends", rx_dv, 0);

    // T not followed by R
    send(C_J); send(C_K); send(C_T); send(DC[7]);
    chk("R4 T then data er", rx_er, 1);
    send(DC[7]); chk("R4 closed after bad end", rx_dv, 0);
    send(C_I);

    // lock timeout lands on an invalid group inside a frame
    c0 = err_count;
    for (int i = 0; i < WIN - 3; i++) send(DC[9]);
    send(C_J); send(C_K);
    chk("R9 still locked", locked, 1);
    send(C_V);
    chk("R9 timeout unlocks", locked, 0);
    chk("R9 abort no dv", rx_dv, 0);
    chk("R9 abort no er", rx_er, 0);
    chk("R2 flag on abort group", sym_invalid, 1);
    chk("R7 abort not counted", err_count, c0);
    send(C_J); send(C_K); send(DC[0]); chk("R9 ignored while unlocked", rx_dv, 0);
    send(C_I); chk("R9 relock", locked, 1);

    // wrap-around
    c0 = err_count;
    n = (1 << CNT_W) - c0;
    for (int f = 0; f < n; f++) begin
      send(C_I); send(C_J); send(C_K); send(C_V); send(C_T); send(C_R);
      if (f == n - 2) chk("R8 at max", err_count, (1 << CNT_W) - 1);
    end
    chk("R8 wraps to zero", err_count, 0);
    send(C_I);
    gap(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule